// File: doc/BRIEF.md
# Two-Lane Skippable Post-Processing Pipeline for Q8.8 Vectors

This block sits behind a matrix-multiply array and finishes each result before it is stored. Every lane carries one signed Q8.8 word per clock: 16 bits, 8 integer and 8 fraction. Each lane passes through the same fixed chain of four stages: bias add, leaky ReLU, loss gradient and leaky ReLU slope. A 4-bit route word chooses which of the four stages take part. An enabled stage registers its result and adds one clock. A skipped stage hands data and valid straight on, with no register.

Two lanes run side by side, so the block accepts two values per clock. The per-lane bias and target inputs are held steady for a whole layer and are read directly, not captured with each beat. A register in an enabled stage loads only when its incoming valid is high. All arithmetic clamps at the Q8.8 limits instead of wrapping.

Top module: `vec_post_pipe`

## Requirements
- R1: While reset is high, every stage register clears its data, pre-activation copy and valid to zero. On the clock after reset, with route bit 3 set, `res_valid` is 0 and `res_data` is 0.
- R2: Route bit 3 enables the bias stage, which outputs X + b. With route `1000`, a beat presented with valid high appears on the outputs exactly one clock later with valid high.
- R3: The bias sum clamps to 0x7FFF on positive overflow and to 0x8000 on negative overflow.
- R4: An enabled stage raises its valid only for a clock after a beat whose valid was high. In a clock where the incoming valid is low, the stage drops its valid and keeps its data word unchanged.
- R5: Route bit 2 enables leaky ReLU, with one clock of latency. A negative input is shifted arithmetically right by 6 (slope 1/64). A zero or positive input passes unchanged.
- R6: Route bit 1 enables the loss stage, with one clock of latency. It outputs 2·(H − Y), where Y is the lane target, clamped to 0x7FFF or 0x8000.
- R7: Route bit 0 enables the slope stage, with one clock of latency. It outputs 0x0100 when the pre-activation Z is greater than zero and 0x0004 otherwise. Z is the bias result, or the raw lane input when the bias stage is skipped.
- R8: With route `0000`, the outputs equal the inputs in the same cycle, for both data and valid.
- R9: Route `1100` outputs leakyReLU(X + b) two clocks after the input beat.
- R10: Route `1110` outputs 2·(leakyReLU(X + b) − Y) after three clocks. Route `1111` outputs the slope of X + b after four clocks. Route `1011` outputs the slope of X + b after three clocks.
- R11: The two lanes are independent. A beat on one lane does not change the other lane's valid or data. The data word of lane i is bits [16·i+15 : 16·i] of each packed bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| path_sel | input | 4 | Route word; bit 3 bias, bit 2 leaky ReLU, bit 1 loss, bit 0 slope |
| lane_valid | input | LANES | Per-lane beat valid from the array |
| lane_data | input | 16·LANES | Per-lane Q8.8 array result |
| lane_bias | input | 16·LANES | Per-lane bias scalar, held for a layer |
| lane_target | input | 16·LANES | Per-lane target Y for the loss stage |
| res_valid | output | LANES | Per-lane result valid |
| res_data | output | 16·LANES | Per-lane Q8.8 result |

## Verification
Each route word is exercised with operands chosen so that a wrong stage order or a missing stage gives a different value. Examples are a negative bias sum fed to leaky ReLU, and a pre-activation whose sign differs from the raw input's sign. Boundary operands push the bias adder and the loss stage past both ends of the Q8.8 range, which separates clamping from wrap-around. Directed beats with valid dropped, and beats on only one lane, show whether stale data is held correctly and whether the lanes leak into each other.

// File: rtl/vpp_pkg.sv
package vpp_pkg;
    localparam int DW          = 16;
    localparam int NSTAGE      = 4;
    localparam int LEAK_SHIFT  = 6;

    typedef logic signed [DW-1:0]  q88_t;
    typedef logic signed [DW+1:0]  wide_t;

    localparam q88_t Q_MAX  = 16'sh7FFF;
    localparam q88_t Q_MIN  = 16'sh8000;
    localparam q88_t Q_ONE  = 16'sh0100;
    localparam q88_t Q_LEAK = 16'sh0004;

    typedef enum logic [1:0] {
        ST_BIAS  = 2'd0,
        ST_LRELU = 2'd1,
        ST_LOSS  = 2'd2,
        ST_SLOPE = 2'd3
    } stage_kind_t;

    typedef struct packed {
        logic valid;
        q88_t data;
        q88_t z;
    } beat_t;

    function automatic wide_t widen(input q88_t v);
        return {{2{v[DW-1]}}, v};
    endfunction

    function automatic q88_t clamp(input wide_t v);
        if (v > 18'sd32767)
            return Q_MAX;
        else if (v < -18'sd32768)
            return Q_MIN;
        else
            return v[DW-1:0];
    endfunction

    function automatic q88_t sat_add(input q88_t a, input q88_t b);
        return clamp(widen(a) + widen(b));
    endfunction

    function automatic q88_t leaky(input q88_t x);
        return x[DW-1] ? (x >>> LEAK_SHIFT) : x;
    endfunction

    function automatic q88_t loss_grad(input q88_t h, input q88_t y);
        wide_t d;
        d = widen(h) - widen(y);
        return clamp(d <<< 1);
    endfunction

    function automatic q88_t leaky_slope(input q88_t z);
        return (z > 16'sd0) ? Q_ONE : Q_LEAK;
    endfunction
endpackage

// File: rtl/vpp_stage.sv
module vpp_stage
    import vpp_pkg::*;
#(
    parameter stage_kind_t KIND = ST_BIAS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  q88_t  side,
    input  beat_t din,
    output beat_t dout
);
    beat_t calc;
    beat_t held;

    always_comb begin
        calc = din;
        case (KIND)
            ST_BIAS: begin
                calc.data = sat_add(din.data, side);
                calc.z    = calc.data;
            end
            ST_LRELU: calc.data = leaky(din.data);
            ST_LOSS:  calc.data = loss_grad(din.data, side);
            default:  calc.data = leaky_slope(din.z);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (din.valid) begin
            held <= calc;
        end else begin
            held.valid <= 1'b0;
        end
    end

    assign dout = en ? held : din;
endmodule

// File: rtl/vpp_lane.sv
module vpp_lane
    import vpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSTAGE-1:0] path_sel,
    input  logic              in_valid,
    input  q88_t              in_data,
    input  q88_t              bias,
    input  q88_t              target,
    output logic              out_valid,
    output q88_t              out_data
);
    beat_t link [NSTAGE+1];

    assign link[0] = '{valid: in_valid, data: in_data, z: in_data};

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        localparam stage_kind_t K = stage_kind_t'(s);
        q88_t side_val;
        assign side_val = (K == ST_BIAS) ? bias : target;

        vpp_stage #(.KIND(K)) u_stage (
            .clk  (clk),
            .rst  (rst),
            .en   (path_sel[NSTAGE-1-s]),
            .side (side_val),
            .din  (link[s]),
            .dout (link[s+1])
        );
    end

    assign out_valid = link[NSTAGE].valid;
    assign out_data  = link[NSTAGE].data;
endmodule

// File: rtl/vec_post_pipe.sv
module vec_post_pipe
    import vpp_pkg::*;
#(
    parameter int LANES = 2,
    localparam int BW   = LANES * DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSTAGE-1:0] path_sel,
    input  logic [LANES-1:0]  lane_valid,
    input  logic [BW-1:0]     lane_data,
    input  logic [BW-1:0]     lane_bias,
    input  logic [BW-1:0]     lane_target,
    output logic [LANES-1:0]  res_valid,
    output logic [BW-1:0]     res_data
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        q88_t lane_out;

        vpp_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .path_sel  (path_sel),
            .in_valid  (lane_valid[i]),
            .in_data   (lane_data[i*DW +: DW]),
            .bias      (lane_bias[i*DW +: DW]),
            .target    (lane_target[i*DW +: DW]),
            .out_valid (res_valid[i]),
            .out_data  (lane_out)
        );

        assign res_data[i*DW +: DW] = lane_out;
    end
endmodule

// File: rtl/vpp_checker.sv
module vpp_checker
    import vpp_pkg::*;
#(
    parameter int LANES = 2,
    localparam int BW   = LANES * DW
) (
    input logic              clk,
    input logic              rst,
    input logic [NSTAGE-1:0] path_sel,
    input logic [LANES-1:0]  lane_valid,
    input logic [BW-1:0]     lane_data,
    input logic [LANES-1:0]  res_valid,
    input logic [BW-1:0]     res_data
);
    p_reset_clear_r1: assert property (@(posedge clk)
        ($past(rst) && path_sel[3]) |-> (res_valid == '0));

    p_bias_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (path_sel == 4'b1000 && lane_valid[0]) |=> (path_sel != 4'b1000 || res_valid[0]));

    p_valid_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (path_sel == 4'b1000 && !lane_valid[0]) |=> (path_sel != 4'b1000 || !res_valid[0]));

    p_slope_codes_r7: assert property (@(posedge clk) disable iff (rst)
        (path_sel[0] && res_valid[0]) |->
            (res_data[DW-1:0] == Q_ONE || res_data[DW-1:0] == Q_LEAK));

    p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        (path_sel == 4'b0000) |-> (res_valid == lane_valid && res_data == lane_data));
endmodule

bind vec_post_pipe vpp_checker #(.LANES(LANES)) u_vpp_checker (
    .clk        (clk),
    .rst        (rst),
    .path_sel   (path_sel),
    .lane_valid (lane_valid),
    .lane_data  (lane_data),
    .res_valid  (res_valid),
    .res_data   (res_data)
);

// File: tb/test_vec_post_pipe.sv
module test_vec_post_pipe;
    localparam int LN = 2;
    localparam int W  = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [3:0]      path_sel = 4'b1100;
    logic [LN-1:0]   lane_valid = '0;
    logic [LN*W-1:0] lane_data = '0;
    logic [LN*W-1:0] lane_bias = '0;
    logic [LN*W-1:0] lane_target = '0;
    logic [LN-1:0]   res_valid;
    logic [LN*W-1:0] res_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5ns clk = ~clk;

    vec_post_pipe #(.LANES(LN)) i_vec_post_pipe (
        .clk(clk), .rst(rst), .path_sel(path_sel),
        .lane_valid(lane_valid), .lane_data(lane_data),
        .lane_bias(lane_bias), .lane_target(lane_target),
        .res_valid(res_valid), .res_data(res_data)
    );

    typedef struct packed {
        logic [3:0]  p;
        logic [15:0] x;
        logic [15:0] b;
        logic [15:0] y;
        logic [15:0] e;
        logic [2:0]  lat;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{4'b1000, 16'h0180, 16'h0040, 16'h0000, 16'h01C0, 3'd1},  // R2
        '{4'b1000, 16'h7F00, 16'h0200, 16'h0000, 16'h7FFF, 3'd1},  // R3 high
        '{4'b1000, 16'h8100, 16'hFE00, 16'h0000, 16'h8000, 3'd1},  // R3 low
        '{4'b0100, 16'hFC00, 16'h0000, 16'h0000, 16'hFFF0, 3'd1},  // R5
        '{4'b0100, 16'h0300, 16'h0000, 16'h0000, 16'h0300, 3'd1},  // R5
        '{4'b0100, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 3'd1},  // R5
        '{4'b0010, 16'h0200, 16'h0000, 16'h0080, 16'h0300, 3'd1},  // R6
        '{4'b0010, 16'h7000, 16'h0000, 16'h9000, 16'h7FFF, 3'd1},  // R6
        '{4'b0010, 16'h8000, 16'h0000, 16'h0100, 16'h8000, 3'd1},  // R6
        '{4'b0001, 16'h0001, 16'h0000, 16'h0000, 16'h0100, 3'd1},  // R7
        '{4'b0001, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 3'd1},  // R7
        '{4'b0000, 16'h1234, 16'h0000, 16'h0000, 16'h1234, 3'd0},  // R8
        '{4'b1100, 16'hFD00, 16'h0100, 16'h0000, 16'hFFF8, 3'd2},  // R9
        '{4'b1100, 16'h0100, 16'h0100, 16'h0000, 16'h0200, 3'd2},  // R9
        '{4'b1110, 16'h0100, 16'h0080, 16'h0100, 16'h0100, 3'd3},  // R10
        '{4'b1111, 16'hFF00, 16'h0080, 16'h0000, 16'h0004, 3'd4},  // R10
        '{4'b1111, 16'h0040, 16'h0000, 16'h0000, 16'h0100, 3'd4},  // R10
        '{4'b1011, 16'h0100, 16'h0100, 16'h0000, 16'h0100, 3'd3}   // R10
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] p, input logic [15:0] e);
        case (p)
            4'b1000: return (e == 16'h7FFF || e == 16'h8000) ? "R3" : "R2";
            4'b0100: return "R5";
            4'b0010: return "R6";
            4'b0001: return "R7";
            4'b0000: return "R8";
            4'b1100: return "R9";
            default: return "R10";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(res_valid), 32'(0));
        chk("R1 data in reset", res_data, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", 32'(res_valid), 32'(0));

        // table walk, both lanes carry the same vector
        for (int k = 0; k < NV; k++) begin
            path_sel    = TBL[k].p;
            lane_data   = {LN{TBL[k].x}};
            lane_bias   = {LN{TBL[k].b}};
            lane_target = {LN{TBL[k].y}};
            lane_valid  = '1;
            if (TBL[k].lat == 3'd0) #1ns;
            else repeat (int'(TBL[k].lat)) @(negedge clk);
            chk($sformatf("%s vec%0d valid", req_of(TBL[k].p, TBL[k].e), k), 32'(res_valid), 32'(2'b11));
            chk($sformatf("%s vec%0d data", req_of(TBL[k].p, TBL[k].e), k), res_data, {LN{TBL[k].e}});
            @(negedge clk);
            lane_valid = '0;
            repeat (6) @(negedge clk);
        end

        // R4: valid gating and data hold
        path_sel   = 4'b1000;
        lane_bias  = {LN{16'h0010}};
        lane_data  = {LN{16'h0100}};
        lane_valid = '1;
        @(negedge clk);
        lane_valid = '0;
        lane_data  = {LN{16'h0500}};
        chk("R4 valid after beat", 32'(res_valid), 32'(2'b11));
        chk("R4 data after beat", res_data, {LN{16'h0110}});
        @(negedge clk);
        chk("R4 valid dropped", 32'(res_valid), 32'(0));
        chk("R4 data held", res_data, {LN{16'h0110}});

        // R11: lane independence (lane 0 only)
        lane_data  = {16'h0300, 16'h0200};
        lane_valid = 2'b01;
        @(negedge clk);
        lane_valid = '0;
        chk("R11 lane valid split", 32'(res_valid), 32'(2'b01));
        chk("R11 lane data split", res_data, {16'h0110, 16'h0210});

        // R1: reset mid-run clears held data
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 data after mid reset", res_data, 32'h0);
        chk("R1 valid after mid reset", 32'(res_valid), 32'(0));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule